// File: doc/BRIEF.md
# Commit Thread Selector

This block picks the hardware thread that may retire an instruction in one commit slot of a multithreaded out-of-order core. For every thread it receives a status code, a flag saying the thread's reorder buffer is empty, a flag saying that buffer's head instruction is ready, and the head's sequence number. It returns a valid flag and a thread index. The caller may query it once for each commit slot in a cycle.

Three policies are available. Oldest-first grants the ready thread whose head instruction is oldest. The greedy policy behaves exactly like oldest-first. Rotating priority grants the first qualifying thread in a priority list. A grant strobe from the caller then moves that thread to the back of the list.

The selection path is purely combinational. The only state is the rotating priority list. With a single thread configured, the block reports that thread whenever its status allows retirement, and leaves the readiness check to the caller.

Top module: `commit_thr_sel`

## Requirements
- R1: Status is a 3-bit code per thread: 0 idle, 1 running, 2 squashing, 3 trap wait, 4 fetch-trap wait, 5 to 7 unused. Only 0, 1 and 4 make a thread eligible, and an ineligible thread is never selected.
- R2: Under oldest-first (policy 2), the candidates are the threads that are eligible, non-empty and head-ready. Among them the block selects the one with the smallest head sequence number.
- R3: Under oldest-first, equal sequence numbers resolve to the lowest thread index.
- R4: Policy 0 (greedy) and the unused policy 3 select exactly as policy 2.
- R5: Under rotating priority (policy 1), the block scans the priority list from the front and selects the first eligible thread whose head is ready.
- R6: A grant strobe while policy 1 is active and the selection is valid moves the selected thread to the back of the list at the next clock edge. The other threads keep their relative order.
- R7: The list does not change without a grant strobe. It also does not change on a strobe while any other policy is active.
- R8: Reset sets the list to thread-index order, 0 first.
- R9: With no qualifying thread, valid is low and the index is 0.
- R10: With one thread configured, valid equals that thread's eligibility, regardless of the empty and ready flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| policy_i | input | 2 | 0 greedy, 1 rotating, 2 oldest-first, 3 as 2 |
| status_i | input | 3*N_THR | Per-thread status code, thread t at bits [3t+2:3t] |
| rob_empty_i | input | N_THR | Per-thread reorder buffer empty |
| head_rdy_i | input | N_THR | Per-thread head instruction ready |
| head_seq_i | input | SEQ_W*N_THR | Per-thread head sequence number, thread t at slice t |
| grant_i | input | 1 | Caller retired the selected thread this slot |
| sel_valid_o | output | 1 | A thread is selected |
| sel_tid_o | output | TID_W | Selected thread index |

## Verification
The assertions assume that the head-ready flag is never raised while the thread's buffer is empty. They also assume that the sequence numbers of different threads do not wrap during the window being compared, so a plain unsigned comparison orders them. Stimulus keeps every head-ready thread non-empty in the rotating tests. The oldest-first vectors use small, non-wrapping sequence numbers, and equal values appear only where the tie-break rule is being tested. Grant strobes are raised only while the selection is valid.

// File: rtl/commit_thr_sel_pkg.sv
package commit_thr_sel_pkg;

  typedef enum logic [2:0] {
    TS_IDLE       = 3'd0,
    TS_RUN        = 3'd1,
    TS_SQUASH     = 3'd2,
    TS_TRAP_WAIT  = 3'd3,
    TS_FTRAP_WAIT = 3'd4
  } thr_state_e;

  typedef enum logic [1:0] {
    POL_GREEDY = 2'd0,
    POL_ROTATE = 2'd1,
    POL_AGE    = 2'd2
  } pol_e;

  localparam int unsigned ST_W = 3;

  function automatic logic state_elig(logic [ST_W-1:0] st);
    return (st == TS_IDLE) || (st == TS_RUN) || (st == TS_FTRAP_WAIT);
  endfunction

endpackage

// File: rtl/thr_elig.sv
module thr_elig
  import commit_thr_sel_pkg::*;
#(
  parameter int unsigned N_THR = 4
) (
  input  logic [ST_W*N_THR-1:0] status_i,
  output logic [N_THR-1:0]      elig_o
);

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    assign elig_o[t] = state_elig(status_i[t*ST_W +: ST_W]);
  end

endmodule

// File: rtl/thr_age_pick.sv
module thr_age_pick #(
  parameter int unsigned N_THR = 4,
  parameter int unsigned SEQ_W = 8,
  parameter int unsigned TID_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_THR-1:0]       cand_i,
  input  logic [SEQ_W*N_THR-1:0] seq_i,
  output logic                   valid_o,
  output logic [TID_W-1:0]       tid_o
);

  logic [SEQ_W-1:0] seq_a [N_THR];
  logic [SEQ_W-1:0] best;

  for (genvar t = 0; t < N_THR; t++) begin : g_seq
    assign seq_a[t] = seq_i[t*SEQ_W +: SEQ_W];
  end

  // linear scan, strict < keeps lowest index on ties
  always_comb begin
    valid_o = 1'b0;
    tid_o   = '0;
    best    = '0;
    for (int i = 0; i < N_THR; i++) begin
      if (cand_i[i] && (!valid_o || seq_a[i] < best)) begin
        valid_o = 1'b1;
        tid_o   = TID_W'(i);
        best    = seq_a[i];
      end
    end
  end

  // assertion support: independent view of the winner
  logic older_seen, lower_tie;
  always_comb begin
    older_seen = 1'b0;
    lower_tie  = 1'b0;
    for (int i = 0; i < N_THR; i++) begin
      if (cand_i[i] && valid_o) begin
        if (seq_a[i] < seq_a[tid_o]) older_seen = 1'b1;
        if (seq_a[i] == seq_a[tid_o] && TID_W'(i) < tid_o) lower_tie = 1'b1;
      end
    end
  end

  p_oldest_min_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cand_i[tid_o] && !older_seen));
  p_tie_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !lower_tie);
  p_none_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_i == '0) |-> (!valid_o && tid_o == '0));

endmodule

// File: rtl/thr_rr_order.sv
module thr_rr_order #(
  parameter int unsigned N_THR = 4,
  parameter int unsigned TID_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_THR-1:0] cand_i,
  input  logic             grant_i,
  output logic             valid_o,
  output logic [TID_W-1:0] tid_o
);

  logic [TID_W-1:0] order_q [N_THR];
  logic [TID_W-1:0] order_d [N_THR];
  int unsigned      hit_pos;

  always_comb begin
    valid_o = 1'b0;
    tid_o   = '0;
    hit_pos = 0;
    for (int p = 0; p < N_THR; p++) begin
      if (!valid_o && cand_i[order_q[p]]) begin
        valid_o = 1'b1;
        tid_o   = order_q[p];
        hit_pos = p;
      end
    end
  end

  // remove winner, close the gap, append at back
  always_comb begin
    for (int p = 0; p < N_THR; p++) order_d[p] = order_q[p];
    if (grant_i && valid_o) begin
      for (int p = 0; p < N_THR - 1; p++) begin
        if (p >= hit_pos) order_d[p] = order_q[p+1];
      end
      order_d[N_THR-1] = tid_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < N_THR; p++) order_q[p] <= TID_W'(p);
    end else begin
      for (int p = 0; p < N_THR; p++) order_q[p] <= order_d[p];
    end
  end

  logic [N_THR-1:0] seen;
  always_comb begin
    seen = '0;
    for (int p = 0; p < N_THR; p++) seen[order_q[p]] = 1'b1;
  end

  p_perm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(seen) == N_THR);
  p_back_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && valid_o) |=> (order_q[N_THR-1] == $past(tid_o)));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_i |=> (order_q[0] == $past(order_q[0]) && order_q[N_THR-1] == $past(order_q[N_THR-1])));
  p_pick_cand_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cand_i[tid_o]);

endmodule

// File: rtl/commit_thr_sel.sv
module commit_thr_sel
  import commit_thr_sel_pkg::*;
#(
  parameter int unsigned N_THR = 4,
  parameter int unsigned SEQ_W = 8,
  localparam int unsigned TID_W = (N_THR > 1) ? $clog2(N_THR) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             policy_i,
  input  logic [ST_W*N_THR-1:0]  status_i,
  input  logic [N_THR-1:0]       rob_empty_i,
  input  logic [N_THR-1:0]       head_rdy_i,
  input  logic [SEQ_W*N_THR-1:0] head_seq_i,
  input  logic                   grant_i,
  output logic                   sel_valid_o,
  output logic [TID_W-1:0]       sel_tid_o
);

  logic [N_THR-1:0] elig;

  thr_elig #(.N_THR(N_THR)) i_elig (
    .status_i (status_i),
    .elig_o   (elig)
  );

  if (N_THR == 1) begin : g_single
    // caller checks readiness
    assign sel_valid_o = elig[0];
    assign sel_tid_o   = '0;
  end else begin : g_multi
    logic             age_valid, rr_valid;
    logic [TID_W-1:0] age_tid, rr_tid;
    logic             is_rot;

    assign is_rot = (policy_i == POL_ROTATE);

    thr_age_pick #(.N_THR(N_THR), .SEQ_W(SEQ_W), .TID_W(TID_W)) i_age (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cand_i  (elig & ~rob_empty_i & head_rdy_i),
      .seq_i   (head_seq_i),
      .valid_o (age_valid),
      .tid_o   (age_tid)
    );

    thr_rr_order #(.N_THR(N_THR), .TID_W(TID_W)) i_rr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cand_i  (elig & head_rdy_i),
      .grant_i (grant_i && is_rot),
      .valid_o (rr_valid),
      .tid_o   (rr_tid)
    );

    assign sel_valid_o = is_rot ? rr_valid : age_valid;
    assign sel_tid_o   = is_rot ? rr_tid   : age_tid;
  end

  p_sel_elig_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> elig[sel_tid_o]);
  p_idle_tid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_valid_o |-> (sel_tid_o == '0));

endmodule

// File: tb/test_commit_thr_sel.sv
module test_commit_thr_sel;

  localparam int N  = 4;
  localparam int SW = 8;

  typedef struct packed {
    logic [1:0]    pol;
    logic [11:0]   st;
    logic [3:0]    emp;
    logic [3:0]    rdy;
    logic [31:0]   seq;
    logic          ev;
    logic [1:0]    et;
    logic [3:0]    req;
  } vec_t;

  localparam logic [11:0] ALLRUN = {3'd1, 3'd1, 3'd1, 3'd1};

  // seq and status packed thread 3 first
  localparam vec_t VECS [13] = '{
    '{2'd2, ALLRUN, 4'h0, 4'hF, {8'd40, 8'd30, 8'd20, 8'd10}, 1'b1, 2'd0, 4'd2},  // R2
    '{2'd2, ALLRUN, 4'h0, 4'hF, {8'd5,  8'd30, 8'd20, 8'd10}, 1'b1, 2'd3, 4'd2},  // R2
    '{2'd2, ALLRUN, 4'h0, 4'h7, {8'd5,  8'd30, 8'd20, 8'd10}, 1'b1, 2'd0, 4'd2},  // R2
    '{2'd2, ALLRUN, 4'h0, 4'hF, {8'd7,  8'd9,  8'd7,  8'd9},  1'b1, 2'd1, 4'd3},  // R3
    '{2'd0, ALLRUN, 4'h0, 4'hF, {8'd5,  8'd30, 8'd20, 8'd10}, 1'b1, 2'd3, 4'd4},  // R4
    '{2'd3, ALLRUN, 4'h0, 4'hF, {8'd5,  8'd30, 8'd20, 8'd10}, 1'b1, 2'd3, 4'd4},  // R4
    '{2'd2, {3'd2, 3'd1, 3'd1, 3'd1}, 4'h0, 4'hF, {8'd5, 8'd30, 8'd20, 8'd10}, 1'b1, 2'd0, 4'd1}, // R1
    '{2'd2, {3'd3, 3'd1, 3'd1, 3'd1}, 4'h0, 4'hF, {8'd5, 8'd30, 8'd20, 8'd10}, 1'b1, 2'd0, 4'd1}, // R1
    '{2'd2, {3'd4, 3'd1, 3'd1, 3'd1}, 4'h0, 4'hF, {8'd5, 8'd30, 8'd20, 8'd10}, 1'b1, 2'd3, 4'd1}, // R1
    '{2'd2, {3'd0, 3'd1, 3'd1, 3'd1}, 4'h0, 4'hF, {8'd5, 8'd30, 8'd20, 8'd10}, 1'b1, 2'd3, 4'd1}, // R1
    '{2'd2, ALLRUN, 4'h8, 4'hF, {8'd5,  8'd30, 8'd20, 8'd10}, 1'b1, 2'd0, 4'd2},  // R2
    '{2'd2, ALLRUN, 4'h0, 4'h0, {8'd5,  8'd30, 8'd20, 8'd10}, 1'b0, 2'd0, 4'd9},  // R9
    '{2'd2, {3'd2, 3'd2, 3'd2, 3'd2}, 4'h0, 4'hF, {8'd5, 8'd30, 8'd20, 8'd10}, 1'b0, 2'd0, 4'd9}  // R9
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  policy = 2'd2;
  logic [11:0] status = ALLRUN;
  logic [3:0]  empty = 4'h0;
  logic [3:0]  rdy = 4'h0;
  logic [31:0] seq = '0;
  logic        grant = 1'b0;
  logic        sel_valid;
  logic [1:0]  sel_tid;

  logic [2:0]  s1_status = 3'd1;
  logic        s1_empty = 1'b1;
  logic        s1_rdy = 1'b0;
  logic        s1_valid;
  logic [0:0]  s1_tid;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  commit_thr_sel #(.N_THR(N), .SEQ_W(SW)) i_commit_thr_sel (
    .clk_i (clk), .rst_ni (rst_n), .policy_i (policy), .status_i (status),
    .rob_empty_i (empty), .head_rdy_i (rdy), .head_seq_i (seq),
    .grant_i (grant), .sel_valid_o (sel_valid), .sel_tid_o (sel_tid)
  );

  commit_thr_sel #(.N_THR(1), .SEQ_W(SW)) i_commit_thr_sel_single (
    .clk_i (clk), .rst_ni (rst_n), .policy_i (2'd1), .status_i (s1_status),
    .rob_empty_i (s1_empty), .head_rdy_i (s1_rdy), .head_seq_i (8'd0),
    .grant_i (1'b0), .sel_valid_o (s1_valid), .sel_tid_o (s1_tid)
  );

  task automatic check(input logic v, input logic [1:0] t,
                       input logic ev, input logic [1:0] et, input string req);
    n_chk++;
    if (v !== ev || t !== et) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
               req, v, t, ev, et);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic pulse_grant();
    @(negedge clk) grant = 1'b1;
    @(negedge clk) grant = 1'b0;
    #1;
  endtask

  initial begin
    #100000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      policy = VECS[i].pol; status = VECS[i].st; empty = VECS[i].emp;
      rdy = VECS[i].rdy; seq = VECS[i].seq;
      #1;
      check(sel_valid, sel_tid, VECS[i].ev, VECS[i].et,
            $sformatf("R%0d vec%0d", VECS[i].req, i));
    end

    // rotating priority directed
    @(negedge clk);
    policy = 2'd1; status = ALLRUN; empty = 4'h0; rdy = 4'hF; seq = '0;
    #1;
    check(sel_valid, sel_tid, 1'b1, 2'd0, "R8 reset order front");
    settle();
    check(sel_valid, sel_tid, 1'b1, 2'd0, "R7 no grant no rotate");
    pulse_grant();
    check(sel_valid, sel_tid, 1'b1, 2'd1, "R6 rotate once");
    pulse_grant();
    check(sel_valid, sel_tid, 1'b1, 2'd2, "R6 rotate twice");
    @(negedge clk) rdy = 4'b1011;
    #1;
    check(sel_valid, sel_tid, 1'b1, 2'd3, "R5 skip not ready");
    pulse_grant();
    @(negedge clk) rdy = 4'hF;
    #1;
    check(sel_valid, sel_tid, 1'b1, 2'd2, "R6 order kept after mid grant");
    @(negedge clk) policy = 2'd2; seq = {8'd4, 8'd3, 8'd2, 8'd1};
    pulse_grant();
    @(negedge clk) policy = 2'd1;
    #1;
    check(sel_valid, sel_tid, 1'b1, 2'd2, "R7 grant under age policy ignored");
    @(negedge clk) status = {3'd1, 3'd2, 3'd1, 3'd1};
    #1;
    check(sel_valid, sel_tid, 1'b1, 2'd0, "R1 rotating skips squashing");
    @(negedge clk) rdy = 4'h0;
    #1;
    check(sel_valid, sel_tid, 1'b0, 2'd0, "R9 rotating none ready");

    @(negedge clk) rst_n = 1'b0; status = ALLRUN; rdy = 4'hF;
    @(negedge clk) rst_n = 1'b1;
    #1;
    check(sel_valid, sel_tid, 1'b1, 2'd0, "R8 reset restores order");

    // single thread
    @(negedge clk) s1_status = 3'd1; s1_empty = 1'b1; s1_rdy = 1'b0;
    #1;
    check(s1_valid, {1'b0, s1_tid}, 1'b1, 2'd0, "R10 single running");
    @(negedge clk) s1_status = 3'd2;
    #1;
    check(s1_valid, {1'b0, s1_tid}, 1'b0, 2'd0, "R10 single squashing");
    @(negedge clk) s1_status = 3'd4;
    #1;
    check(s1_valid, {1'b0, s1_tid}, 1'b1, 2'd0, "R10 single fetch trap");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule